// File: doc/BRIEF.md
# Memory Word Protection with Single-Error Correction, Double-Error Detection and Background Scrubbing

This block is a small on-chip register-file memory whose every 32-bit word is held together with 7 check bits, 39 bits in all. A user write encodes the data and stores the full codeword. A user read decodes the stored codeword. A clean word is returned as it is. A word with one flipped bit is returned with that bit repaired. A word with two flipped bits is reported as uncorrectable and is never silently "fixed". Read results appear one clock after the request, together with one-cycle pulses for a corrected event and for an uncorrectable event.

The check bits come from a parity-check matrix built only from odd-weight columns. Check bit j has the weight-1 column with only bit j set. Each data bit takes a weight-3 column, and further odd weights would be used if the data were wider. The syndrome is the stored check bits XOR the check bits recomputed from the stored data. A zero syndrome means no error. An odd-weight syndrome equal to one column names the failing bit. Any other nonzero syndrome is uncorrectable.

While `scrub_en` is high and the user port carries no request, a scrub engine walks the addresses in ascending order and wraps around at the top. It reads each word and writes back only words that needed a single-bit repair. It records the address of the latest uncorrectable word it met. Its states are `SC_OFF` (engine disabled), `SC_READ` (decode the current address) and `SC_WRITE` (store the repaired codeword). Its transitions are:
- `SC_OFF` to `SC_READ` when enabled.
- `SC_READ` stays in `SC_READ` and advances when the word is clean or uncorrectable.
- `SC_READ` goes to `SC_WRITE` when a repair is pending.
- `SC_WRITE` goes to `SC_READ` and advances after the write-back.
- `SC_WRITE` goes to `SC_READ` at the same address when a user request preempts it.
- Any state goes to `SC_OFF` when disabled.

A test input XORs a mask straight into one stored codeword, so that faults can be placed in the array.

Top module: `ecc_scrub_mem`

## Requirements
- R1: After reset, `rd_valid`, `rd_ce`, `rd_ue`, `scr_ce` and `scr_ue` are low and `scr_ue_addr` is 0. Every stored word is all-zero, which is a valid codeword.
- R2: A read of a word written through the user port, with no fault injected, returns the written data with `rd_ce` and `rd_ue` low. Stored codeword bits [31:0] hold the data and bits [38:32] hold the check bits, bit 32+j being check bit j.
- R3: A single flipped bit anywhere in the 39-bit stored codeword, data or check bit, is repaired on read. `rd_data` equals the written data, `rd_ce` is high and `rd_ue` is low.
- R4: Two flipped bits in one stored codeword give `rd_ue` high and `rd_ce` low.
- R5: A read request (`req` high, `we` low) sampled at one rising edge gives `rd_valid` high for exactly the following cycle, with that read's data and flags.
- R6: The scrub engine reads or writes the array only in cycles where `scrub_en` is high and `req` is low. While `req` is held high, no scrub pulse occurs.
- R7: When a scrub read finds a single-bit error, the repaired codeword is written back, so that a later user read of that word reports no error. `scr_ce` pulses once for that read.
- R8: When a scrub read finds an uncorrectable word, the word is left unchanged, `scr_ue` pulses and `scr_ue_addr` takes that address. A later user read still reports `rd_ue`.
- R9: `rd_ce` and `rd_ue` are never high together.
- R10: A user request in the cycle a scrub write-back is due cancels the write-back, and the engine re-reads the same address. A user write always lands, and a word rewritten by the user reads back clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | User request valid |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | User word address |
| wdata | input | 32 | User write data |
| rd_valid | output | 1 | Read result valid, one cycle after the request |
| rd_data | output | 32 | Read data, repaired when possible |
| rd_ce | output | 1 | Pulse: user read repaired a single-bit error |
| rd_ue | output | 1 | Pulse: user read found an uncorrectable word |
| scrub_en | input | 1 | Enables the background scrub engine |
| scr_ce | output | 1 | Pulse: scrub read found a single-bit error |
| scr_ue | output | 1 | Pulse: scrub read found an uncorrectable word |
| scr_ue_addr | output | 4 | Address of the latest uncorrectable scrub read |
| flip_en | input | 1 | Fault injection strobe |
| flip_addr | input | 4 | Word that receives the injected mask |
| flip_mask | input | 39 | Bits to invert in the stored codeword |

## Verification
The read path is tried with words that carry no flip, one flip at a random position among all 39 bits, a flip aimed at a check bit, and two distinct random flips. This separates pass-through, repair of data bits, repair of check bits, and the refusal to miscorrect a double error. The scrub engine is tried three ways: with a fully idle port, with the port held busy for many cycles, and with a request every third cycle. These show that a single error is written back, that an uncorrectable word is left alone and reported with its address, that the engine never steals a busy cycle, and that a preempted write-back restarts and still completes. A user rewrite of a faulty word confirms that user writes take priority.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int MAXC = 16;

    function automatic int popcount(input int v);
        int n;
        n = 0;
        for (int b = 0; b < 31; b++) begin
            n += (v >> b) & 1;
        end
        return n;
    endfunction

    // smallest check width c with 2^(c-1) >= k + c (single correct, double detect)
    function automatic int check_width(input int data_w);
        int c;
        c = 2;
        while ((1 << (c - 1)) < (data_w + c)) begin
            c++;
        end
        return c;
    endfunction

    // column of data bit idx: odd weights from 3 upward, ascending value inside a weight
    function automatic logic [MAXC-1:0] data_column(input int idx, input int chk_w);
        logic [MAXC-1:0] col;
        int seen;
        bit found;
        col   = '0;
        seen  = 0;
        found = 1'b0;
        for (int w = 3; w <= chk_w; w += 2) begin
            for (int v = 1; v < (1 << chk_w); v++) begin
                if (!found && popcount(v) == w) begin
                    if (seen == idx) begin
                        col   = MAXC'(v);
                        found = 1'b1;
                    end
                    seen++;
                end
            end
        end
        return col;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 7
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    logic [CHK_W-1:0] cols [DATA_W];

    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        localparam logic [ecc_pkg::MAXC-1:0] COLF = ecc_pkg::data_column(i, CHK_W);
        assign cols[i] = COLF[CHK_W-1:0];
    end

    always_comb begin
        chk = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data[i]) chk = chk ^ cols[i];
        end
    end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 7,
    localparam int CW    = DATA_W + CHK_W
) (
    input  logic [CW-1:0] cw_in,
    output logic [CW-1:0] cw_fix,
    output logic          ce,
    output logic          ue
);
    logic [CHK_W-1:0]  cols [DATA_W];
    logic [CHK_W-1:0]  recalc;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] data_hit;
    logic [CHK_W-1:0]  chk_hit;
    logic              single;

    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        localparam logic [ecc_pkg::MAXC-1:0] COLF = ecc_pkg::data_column(i, CHK_W);
        assign cols[i]     = COLF[CHK_W-1:0];
        assign data_hit[i] = (syn == cols[i]);
    end

    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        assign chk_hit[j] = (syn == CHK_W'(1 << j));
    end

    ecc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_recalc (
        .data (cw_in[DATA_W-1:0]),
        .chk  (recalc)
    );

    assign syn    = cw_in[CW-1:DATA_W] ^ recalc;
    assign single = (^syn) && ((|data_hit) || (|chk_hit));
    assign ce     = single;
    assign ue     = (syn != '0) && !single;

    always_comb begin
        cw_fix = cw_in;
        if (single) begin
            cw_fix = cw_in ^ {chk_hit, data_hit};
        end
    end
endmodule

// File: rtl/ecc_array.sv
module ecc_array #(
    parameter int CW     = 39,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_cw,
    input  logic              flip_en,
    input  logic [ADDR_W-1:0] flip_addr,
    input  logic [CW-1:0]     flip_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CW-1:0]     rd_cw
);
    logic [CW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic hit_wr;
        logic hit_flip;
        assign hit_wr   = wr_en   && (wr_addr   == ADDR_W'(g));
        assign hit_flip = flip_en && (flip_addr == ADDR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (hit_wr || hit_flip) begin
                mem[g] <= (hit_wr ? wr_cw : mem[g]) ^ (hit_flip ? flip_mask : '0);
            end
        end
    end

    assign rd_cw = mem[rd_addr];
endmodule

// File: rtl/scrub_fsm.sv
module scrub_fsm #(
    parameter int CW     = 39,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scrub_en,
    input  logic              user_req,
    input  logic              dec_ce,
    input  logic              dec_ue,
    input  logic [CW-1:0]     dec_cw,
    output logic [ADDR_W-1:0] scr_addr,
    output logic              scr_rd,
    output logic              scr_wr,
    output logic [CW-1:0]     scr_wcw,
    output logic              scr_ce,
    output logic              scr_ue,
    output logic [ADDR_W-1:0] scr_ue_addr
);
    typedef enum logic [1:0] {
        SC_OFF   = 2'd0,
        SC_READ  = 2'd1,
        SC_WRITE = 2'd2
    } scrub_state_e;

    scrub_state_e state, state_nx;
    logic         advance;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SC_OFF;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SC_OFF:   if (scrub_en) state_nx = SC_READ;
            SC_READ: begin
                if (!scrub_en)                 state_nx = SC_OFF;
                else if (!user_req && dec_ce)  state_nx = SC_WRITE;
            end
            SC_WRITE: begin
                if (!scrub_en) state_nx = SC_OFF;
                else           state_nx = SC_READ;
            end
            default: state_nx = SC_OFF;
        endcase
    end

    // outputs
    always_comb begin
        scr_rd  = 1'b0;
        scr_wr  = 1'b0;
        unique case (state)
            SC_OFF:   ;
            SC_READ:  scr_rd = scrub_en && !user_req;
            SC_WRITE: scr_wr = scrub_en && !user_req;
            default:  ;
        endcase
        advance = (scr_rd && !dec_ce) || scr_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scr_addr    <= '0;
            scr_wcw     <= '0;
            scr_ce      <= 1'b0;
            scr_ue      <= 1'b0;
            scr_ue_addr <= '0;
        end else begin
            scr_ce <= scr_rd && dec_ce;
            scr_ue <= scr_rd && dec_ue;
            if (scr_rd) scr_wcw <= dec_cw;
            if (scr_rd && dec_ue) scr_ue_addr <= scr_addr;
            if (advance) begin
                scr_addr <= (scr_addr == ADDR_W'(DEPTH - 1)) ? '0 : scr_addr + 1'b1;
            end
        end
    end

    // R7
    wb_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_WRITE && scrub_en && !user_req)
        |=> (scr_addr == (($past(scr_addr) == ADDR_W'(DEPTH - 1)) ? '0 : $past(scr_addr) + 1'b1)));

    // R10
    wb_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_WRITE && scrub_en && user_req)
        |=> (state == SC_READ && $stable(scr_addr)));
endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 16,
    localparam int CHK_W  = ecc_pkg::check_width(DATA_W),
    localparam int CW     = DATA_W + CHK_W,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ce,
    output logic              rd_ue,
    input  logic              scrub_en,
    output logic              scr_ce,
    output logic              scr_ue,
    output logic [ADDR_W-1:0] scr_ue_addr,
    input  logic              flip_en,
    input  logic [ADDR_W-1:0] flip_addr,
    input  logic [CW-1:0]     flip_mask
);
    logic [CHK_W-1:0]  wr_chk;
    logic [CW-1:0]     arr_rd_cw;
    logic [CW-1:0]     dec_cw;
    logic              dec_ce;
    logic              dec_ue;
    logic [ADDR_W-1:0] scr_addr;
    logic              scr_rd;
    logic              scr_wr;
    logic [CW-1:0]     scr_wcw;
    logic              arr_wr;
    logic [ADDR_W-1:0] arr_addr;
    logic [CW-1:0]     arr_wcw;

    ecc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
        .data (wdata),
        .chk  (wr_chk)
    );

    assign arr_addr = req ? addr : scr_addr;
    assign arr_wr   = (req && we) || scr_wr;
    assign arr_wcw  = req ? {wr_chk, wdata} : scr_wcw;

    ecc_array #(.CW(CW), .DEPTH(DEPTH)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (arr_wr),
        .wr_addr   (arr_addr),
        .wr_cw     (arr_wcw),
        .flip_en   (flip_en),
        .flip_addr (flip_addr),
        .flip_mask (flip_mask),
        .rd_addr   (arr_addr),
        .rd_cw     (arr_rd_cw)
    );

    ecc_decoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
        .cw_in  (arr_rd_cw),
        .cw_fix (dec_cw),
        .ce     (dec_ce),
        .ue     (dec_ue)
    );

    scrub_fsm #(.CW(CW), .DEPTH(DEPTH)) u_scrub (
        .clk         (clk),
        .rst_n       (rst_n),
        .scrub_en    (scrub_en),
        .user_req    (req),
        .dec_ce      (dec_ce),
        .dec_ue      (dec_ue),
        .dec_cw      (dec_cw),
        .scr_addr    (scr_addr),
        .scr_rd      (scr_rd),
        .scr_wr      (scr_wr),
        .scr_wcw     (scr_wcw),
        .scr_ce      (scr_ce),
        .scr_ue      (scr_ue),
        .scr_ue_addr (scr_ue_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_ce    <= 1'b0;
            rd_ue    <= 1'b0;
        end else begin
            rd_valid <= req && !we;
            rd_ce    <= req && !we && dec_ce;
            rd_ue    <= req && !we && dec_ue;
            if (req && !we) rd_data <= dec_cw[DATA_W-1:0];
        end
    end

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ce && rd_ue));

    // R5
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rd_valid);

    // R6
    scrub_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_rd || scr_wr) |-> (!req && scrub_en));
endmodule

// File: tb/ecc_scrub_mem_bench.sv
module ecc_scrub_mem_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int AW = 4;
    localparam int CW = 39;

    typedef struct {
        logic [DW-1:0] data;
        logic          ce;
        logic          ue;
        string         tag;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    logic req = 0, we = 0, scrub_en = 0, flip_en = 0;
    logic [AW-1:0] addr = '0, flip_addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [CW-1:0] flip_mask = '0;
    logic rd_valid, rd_ce, rd_ue, scr_ce, scr_ue;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] scr_ue_addr;

    int checks = 0;
    int errors = 0;
    int scr_ce_cnt = 0;
    int scr_ue_cnt = 0;
    logic [DW-1:0] shadow [DEPTH];
    exp_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_scrub_mem u_ecc_scrub_mem (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ce(rd_ce), .rd_ue(rd_ue),
        .scrub_en(scrub_en), .scr_ce(scr_ce), .scr_ue(scr_ue), .scr_ue_addr(scr_ue_addr),
        .flip_en(flip_en), .flip_addr(flip_addr), .flip_mask(flip_mask)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: pops the scoreboard as read results appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (scr_ce) scr_ce_cnt++;
            if (scr_ue) scr_ue_cnt++;
            if (rd_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5 unexpected rd_valid", 64'(rd_valid), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rd_ce == e.ce, {e.tag, " rd_ce"}, 64'(rd_ce), 64'(e.ce));
                    check(rd_ue == e.ue, {e.tag, " rd_ue"}, 64'(rd_ue), 64'(e.ue));
                    if (!e.ue) check(rd_data == e.data, {e.tag, " rd_data"}, 64'(rd_data), 64'(e.data));
                end
            end
        end
    end

    task automatic do_write(input int a, input logic [DW-1:0] d);
        req = 1; we = 1; addr = AW'(a); wdata = d;
        shadow[a] = d;
        @(negedge clk);
        req = 0; we = 0;
    endtask

    // driver: issues a read and pushes the expected result
    task automatic do_read(input int a, input int nflip, input string tag, input bit hold);
        exp_t e;
        e.data = shadow[a];
        e.ce = (nflip == 1);
        e.ue = (nflip == 2);
        e.tag = tag;
        sb.push_back(e);
        req = 1; we = 0; addr = AW'(a);
        @(negedge clk);
        if (!hold) req = 0;
    endtask

    task automatic inject(input int a, input logic [CW-1:0] m);
        flip_en = 1; flip_addr = AW'(a); flip_mask = m;
        @(negedge clk);
        flip_en = 0; flip_mask = '0;
    endtask

    function automatic logic [CW-1:0] rand_mask(input int nflip);
        int p1, p2;
        logic [CW-1:0] m;
        m = '0;
        p1 = $urandom_range(CW - 1);
        p2 = (p1 + 1 + $urandom_range(CW - 2)) % CW;
        if (nflip >= 1) m[p1] = 1'b1;
        if (nflip >= 2) m[p2] = 1'b1;
        return m;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check(!rd_valid && !rd_ce && !rd_ue, "R1 read outputs after reset", 64'({rd_valid, rd_ce, rd_ue}), 64'd0);
        check(!scr_ce && !scr_ue && scr_ue_addr == '0, "R1 scrub outputs after reset", 64'({scr_ce, scr_ue, scr_ue_addr}), 64'd0);
        for (int a = 0; a < DEPTH; a++) shadow[a] = '0;
        do_read(7, 0, "R1 zero word reads clean", 1'b0);

        for (int a = 0; a < DEPTH; a++) do_write(a, $urandom());
        // R2 and R5: back-to-back clean reads
        for (int a = 0; a < DEPTH; a++) do_read(a, 0, "R2 clean read", a != DEPTH - 1);
        @(negedge clk);

        // R3: flip of a check bit only
        inject(4, 39'(1) << 38);
        do_read(4, 1, "R3 check-bit flip", 1'b0);
        do_write(4, $urandom());

        // R3/R4: random fault patterns
        for (int t = 0; t < 60; t++) begin
            int a, n;
            a = $urandom_range(DEPTH - 1);
            n = t % 3;
            inject(a, rand_mask(n));
            do_read(a, n, n == 2 ? "R4 double flip" : (n == 1 ? "R3 single flip" : "R2 no flip"), 1'b0);
            do_write(a, $urandom());
        end
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R5 all reads answered", 64'(sb.size()), 64'd0);

        // R7/R8: idle-port scrub
        inject(3, rand_mask(1));
        inject(9, rand_mask(2));
        scr_ce_cnt = 0; scr_ue_cnt = 0;
        scrub_en = 1;
        repeat (100) @(negedge clk);
        scrub_en = 0;
        repeat (3) @(negedge clk);
        check(scr_ce_cnt == 1, "R7 single scrub repair pulse", 64'(scr_ce_cnt), 64'd1);
        check(scr_ue_cnt >= 1, "R8 scrub uncorrectable pulse", 64'(scr_ue_cnt), 64'd1);
        check(scr_ue_addr == AW'(9), "R8 scrub uncorrectable address", 64'(scr_ue_addr), 64'd9);
        do_read(3, 0, "R7 scrubbed word reads clean", 1'b0);
        do_read(9, 2, "R8 uncorrectable word left as is", 1'b0);

        // R6: busy port starves the scrubber
        scr_ce_cnt = 0; scr_ue_cnt = 0;
        for (int k = 0; k < 30; k++) begin
            scrub_en = 1;
            do_read(0, 0, "R6 read during busy scrub window", 1'b1);
        end
        req = 0; scrub_en = 0;
        repeat (3) @(negedge clk);
        check(scr_ce_cnt == 0 && scr_ue_cnt == 0, "R6 no scrub activity while busy", 64'(scr_ce_cnt + scr_ue_cnt), 64'd0);

        // R10: request every third cycle preempts write-backs, repair still completes
        inject(5, rand_mask(1));
        scr_ce_cnt = 0;
        scrub_en = 1;
        for (int k = 0; k < 40; k++) begin
            repeat (2) @(negedge clk);
            do_read(0, 0, "R10 sporadic read", 1'b0);
        end
        scrub_en = 0;
        repeat (3) @(negedge clk);
        check(scr_ce_cnt >= 1, "R10 repair seen under preemption", 64'(scr_ce_cnt), 64'd1);
        do_read(5, 0, "R10 preempted repair completes", 1'b0);

        // R10: user write overrides an uncorrectable word
        do_write(9, 32'hA5A5_0F0F);
        do_read(9, 0, "R10 user rewrite reads clean", 1'b0);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R5 scoreboard drained", 64'(sb.size()), 64'd0);
        finish_run();
    end
endmodule